// File: doc/BRIEF.md
# Dual 12-bit DAC serial load front end

This block is the digital side of a two-channel 12-bit voltage DAC. A host shifts 16-bit words in over a three-wire link: serial data, serial clock and an active-low select. The word moves through a shift register whose last stage drives a serial output, so several devices can share one link in a chain. Two active-low load strobes copy the 12-bit payload from the shift register into the channel A register, the channel B register, or both. A bit inside the word picks how the strobes act. In direct mode each strobe names its own channel. In addressed mode either strobe fires the transfer, and two address bits in the word pick the target.

All pins are sampled by a faster system clock through two-flop synchronizers, and edges are detected on the synchronized copies. An asynchronous active-low preset input forces both channel registers to zero or to midscale, chosen by a scale-select pin. The two register values are the block's outputs.

Top module: `dual_dac_serial_front`

## Requirements
- R1: A synchronous system reset (`rst` high) clears the shift register, so `sdo` is 0, and sets both channel registers to 0x000.
- R2: Each rising serial-clock edge seen while `cs_n` is low shifts `sdi` into bit 0 of the 16-bit shift register, MSB first. Word layout: bit 15 is the mode bit (1 = addressed, 0 = direct), bit 14 is address B, bit 13 is address A, bit 12 is unused, and bits 11..0 are the payload.
- R3: While `cs_n` is high, serial-clock edges leave the shift register unchanged.
- R4: `sdo` is always driven from bit 15 of the shift register, so it presents the bit that entered 16 shifts earlier.
- R5: In direct mode a falling edge on `lda_n` copies the payload into channel A, and channel B keeps its value.
- R6: In direct mode a falling edge on `ldb_n` loads channel B only. Falling edges on both strobes in the same cycle load both channels.
- R7: In addressed mode a falling edge on either strobe triggers a transfer. A=1,B=0 loads A; A=0,B=1 loads B; A=1,B=1 loads both; A=0,B=0 loads nothing.
- R8: `cs_n` has no effect on strobe operation: a transfer works with `cs_n` low or high.
- R9: While `preset_n` is low, both channel registers are forced at once, without waiting for a clock, to 0x800 if `mid_sel` is 1 and to 0x000 if it is 0.
- R10: A strobe edge that lands in the same system cycle as a shift captures the shift-register contents from before that shift.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than the serial clock |
| rst | input | 1 | Synchronous active-high reset |
| sclk | input | 1 | Serial clock; data shifts on its rising edge |
| sdi | input | 1 | Serial data in, MSB first |
| cs_n | input | 1 | Active-low select; gates shifting only |
| lda_n | input | 1 | Active-low load strobe A |
| ldb_n | input | 1 | Active-low load strobe B |
| preset_n | input | 1 | Asynchronous active-low preset of both channel registers |
| mid_sel | input | 1 | Preset value: 1 gives midscale, 0 gives zero |
| sdo | output | 1 | Serial data out, last shift-register stage |
| dac_a | output | 12 | Channel A register |
| dac_b | output | 12 | Channel B register |

## Verification
The bench sweeps every combination of mode bit, the two address bits and the three strobe patterns, and predicts both channel registers from its own model of the decode. A decode that swaps A and B, or that loads on address 00, shows up as a wrong channel value. It drives a strobe edge and a serial-clock edge on the same cycle; a design that samples the register after the shift loads a payload shifted by one bit. It also clocks with the select high and checks that a later transfer still carries the earlier word, reads the previous word back from `sdo` bit by bit, and checks both preset values right away, without waiting for a clock edge.

// File: rtl/dacfe_pkg.sv
package dacfe_pkg;

    localparam int WORD_W = 16;
    localparam int DATA_W = 12;

    typedef struct packed {
        logic              addr_mode;
        logic              addr_b;
        logic              addr_a;
        logic              spare;
        logic [DATA_W-1:0] payload;
    } frame_t;

    typedef struct packed {
        logic to_b;
        logic to_a;
    } target_t;

    localparam logic [DATA_W-1:0] CODE_ZERO = '0;
    localparam logic [DATA_W-1:0] CODE_MID  = {1'b1, {(DATA_W-1){1'b0}}};

    function automatic target_t pick_targets(input frame_t f,
                                             input logic fall_a,
                                             input logic fall_b);
        target_t t;
        if (f.addr_mode) begin
            t.to_a = (fall_a | fall_b) & f.addr_a;
            t.to_b = (fall_a | fall_b) & f.addr_b;
        end else begin
            t.to_a = fall_a;
            t.to_b = fall_b;
        end
        return t;
    endfunction

    function automatic logic [DATA_W-1:0] preset_code(input logic mid);
        return mid ? CODE_MID : CODE_ZERO;
    endfunction

endpackage

// File: rtl/dacfe_sync.sv
module dacfe_sync #(
    parameter int            W      = 5,
    parameter int            STAGES = 2,
    parameter logic [W-1:0]  INIT   = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] pipe [STAGES];

    always_ff @(posedge clk) begin
        if (rst) pipe[0] <= INIT;
        else     pipe[0] <= d;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) pipe[s] <= INIT;
            else     pipe[s] <= pipe[s-1];
        end
    end

    assign q = pipe[STAGES-1];
endmodule

// File: rtl/dacfe_shifter.sv
module dacfe_shifter
    import dacfe_pkg::*;
#(
    parameter int W = WORD_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         sclk_s,
    input  logic         sdi_s,
    input  logic         cs_n_s,
    output logic [W-1:0] sr_q,
    output logic         sdo
);
    logic sclk_d;
    logic shift_en;

    always_ff @(posedge clk) begin
        if (rst) sclk_d <= 1'b0;
        else     sclk_d <= sclk_s;
    end

    assign shift_en = sclk_s & ~sclk_d & ~cs_n_s;

    always_ff @(posedge clk) begin
        if (rst)           sr_q <= '0;
        else if (shift_en) sr_q <= {sr_q[W-2:0], sdi_s};
    end

    assign sdo = sr_q[W-1];

    AST_SHIFT_IN: assert property (@(posedge clk) disable iff (rst)
        shift_en |=> sr_q[0] == $past(sdi_s)); // R2
    AST_HOLD_DESELECTED: assert property (@(posedge clk) disable iff (rst)
        cs_n_s |=> $stable(sr_q)); // R3
    AST_SDO_CHAIN: assert property (@(posedge clk) disable iff (rst)
        shift_en |=> sdo == $past(sr_q[W-2])); // R4
endmodule

// File: rtl/dacfe_loadctl.sv
module dacfe_loadctl
    import dacfe_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    lda_n_s,
    input  logic    ldb_n_s,
    input  frame_t  frame,
    output target_t ld
);
    logic lda_d, ldb_d;
    logic fall_a, fall_b;

    always_ff @(posedge clk) begin
        if (rst) begin
            lda_d <= 1'b1;
            ldb_d <= 1'b1;
        end else begin
            lda_d <= lda_n_s;
            ldb_d <= ldb_n_s;
        end
    end

    assign fall_a = lda_d & ~lda_n_s;
    assign fall_b = ldb_d & ~ldb_n_s;
    assign ld     = pick_targets(frame, fall_a, fall_b);

    AST_NO_EDGE_NO_LOAD: assert property (@(posedge clk) disable iff (rst)
        (lda_n_s == lda_d && ldb_n_s == ldb_d) |-> ld == '0); // R5
    AST_DIRECT_B_ONLY: assert property (@(posedge clk) disable iff (rst)
        (!frame.addr_mode && ldb_n_s == ldb_d) |-> !ld.to_b); // R6
    AST_ADDR_NONE: assert property (@(posedge clk) disable iff (rst)
        (frame.addr_mode && !frame.addr_a && !frame.addr_b) |-> ld == '0); // R7
endmodule

// File: rtl/dacfe_channel.sv
module dacfe_channel
    import dacfe_pkg::*;
#(
    parameter int DW = DATA_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          preset_n,
    input  logic          mid_sel,
    input  logic          load,
    input  logic [DW-1:0] payload,
    output logic [DW-1:0] code_q
);
    always_ff @(posedge clk or negedge preset_n) begin
        if (!preset_n)  code_q <= preset_code(mid_sel);
        else if (rst)   code_q <= '0;
        else if (load)  code_q <= payload;
    end

    AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (rst || !preset_n)
        load |=> code_q == $past(payload)); // R5
    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst || !preset_n)
        !load |=> $stable(code_q)); // R6
    AST_PRESET_VALUE: assert property (@(posedge clk) disable iff (rst)
        !preset_n |-> code_q == (mid_sel ? CODE_MID : CODE_ZERO)); // R9
endmodule

// File: rtl/dual_dac_serial_front.sv
module dual_dac_serial_front
    import dacfe_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sclk,
    input  logic              sdi,
    input  logic              cs_n,
    input  logic              lda_n,
    input  logic              ldb_n,
    input  logic              preset_n,
    input  logic              mid_sel,
    output logic              sdo,
    output logic [DATA_W-1:0] dac_a,
    output logic [DATA_W-1:0] dac_b
);
    localparam int NPINS = 5;
    // pin order in the synchronizer bus: ldb_n, lda_n, cs_n, sdi, sclk
    localparam logic [NPINS-1:0] PIN_INIT = 5'b11100;

    logic [NPINS-1:0]  pins_s;
    logic [WORD_W-1:0] sr;
    frame_t            frame;
    target_t           ld;
    logic [DATA_W-1:0] codes [2];

    dacfe_sync #(.W(NPINS), .STAGES(SYNC_STAGES), .INIT(PIN_INIT)) sync_i (
        .clk (clk),
        .rst (rst),
        .d   ({ldb_n, lda_n, cs_n, sdi, sclk}),
        .q   (pins_s)
    );

    dacfe_shifter #(.W(WORD_W)) shifter_i (
        .clk    (clk),
        .rst    (rst),
        .sclk_s (pins_s[0]),
        .sdi_s  (pins_s[1]),
        .cs_n_s (pins_s[2]),
        .sr_q   (sr),
        .sdo    (sdo)
    );

    assign frame = frame_t'(sr);

    dacfe_loadctl loadctl_i (
        .clk     (clk),
        .rst     (rst),
        .lda_n_s (pins_s[3]),
        .ldb_n_s (pins_s[4]),
        .frame   (frame),
        .ld      (ld)
    );

    for (genvar c = 0; c < 2; c++) begin : g_chan
        dacfe_channel #(.DW(DATA_W)) chan_i (
            .clk      (clk),
            .rst      (rst),
            .preset_n (preset_n),
            .mid_sel  (mid_sel),
            .load     ((c == 0) ? ld.to_a : ld.to_b),
            .payload  (frame.payload),
            .code_q   (codes[c])
        );
    end

    assign dac_a = codes[0];
    assign dac_b = codes[1];
endmodule

// File: tb/dual_dac_serial_front_tb.sv
module dual_dac_serial_front_tb_top;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sclk = 1'b0, sdi = 1'b0, cs_n = 1'b1;
    logic lda_n = 1'b1, ldb_n = 1'b1;
    logic preset_n = 1'b1, mid_sel = 1'b0;
    logic sdo;
    logic [11:0] dac_a, dac_b;
    int nchk = 0, nfail = 0;
    logic [11:0] exp_a = 12'h000, exp_b = 12'h000;

    always #10 clk = ~clk;

    dual_dac_serial_front dut_i (
        .clk(clk), .rst(rst), .sclk(sclk), .sdi(sdi), .cs_n(cs_n),
        .lda_n(lda_n), .ldb_n(ldb_n), .preset_n(preset_n), .mid_sel(mid_sel),
        .sdo(sdo), .dac_a(dac_a), .dac_b(dac_b)
    );

    task automatic chk(input string req, input logic [11:0] got, input logic [11:0] exp);
        nchk++;
        if (got !== exp) begin
            nfail++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic step();
        repeat (4) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic shift_bit(input logic b);
        sclk = 1'b0; sdi = b; step();
        sclk = 1'b1; step();
    endtask

    task automatic send_word(input logic [15:0] w);
        cs_n = 1'b0;
        for (int i = 15; i >= 0; i--) shift_bit(w[i]);
        sclk = 1'b0; step();
        cs_n = 1'b1; step();
    endtask

    task automatic strobe(input logic a, input logic b);
        lda_n = ~a; ldb_n = ~b; step();
        lda_n = 1'b1; ldb_n = 1'b1; step();
    endtask

    task automatic check_both(input string req);
        chk({req, " chan A"}, dac_a, exp_a);
        chk({req, " chan B"}, dac_b, exp_b);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0; step();
        chk("R1 sdo", {11'd0, sdo}, 12'h000);
        check_both("R1");

        // R5 R6 R7: sweep mode, address and strobe pattern
        for (int m = 0; m < 2; m++) begin
            for (int ab = 0; ab < 4; ab++) begin
                for (int s = 0; s < 3; s++) begin
                    logic [11:0] d;
                    logic sa, sb, ta, tb;
                    d  = 12'((((m * 12 + ab * 3 + s) * 173) + 41) % 4096);
                    sa = (s != 1); sb = (s != 0);
                    send_word({logic'(m), ab[1], ab[0], 1'b0, d});
                    strobe(sa, sb);
                    if (m == 1) begin ta = ab[0]; tb = ab[1]; end
                    else        begin ta = sa;    tb = sb;    end
                    if (ta) exp_a = d;
                    if (tb) exp_b = d;
                    check_both(m == 1 ? "R7" : (s == 0 ? "R5" : "R6"));
                end
            end
        end

        // R4: previous word comes out of sdo while the next word goes in
        begin
            logic [15:0] w1, w2;
            w1 = 16'h5A3C; w2 = 16'h9E71;
            send_word(w1);
            cs_n = 1'b0;
            for (int i = 15; i >= 0; i--) begin
                chk("R4 sdo bit", {11'd0, sdo}, {11'd0, w1[i]});
                shift_bit(w2[i]);
            end
            sclk = 1'b0; step(); cs_n = 1'b1; step();
            chk("R4 sdo after chain", {11'd0, sdo}, {11'd0, w2[15]});
        end

        // R3: clocks with select high leave the word intact
        send_word(16'h0ABC);
        sdi = 1'b1;
        for (int k = 0; k < 5; k++) begin
            sclk = 1'b0; step(); sclk = 1'b1; step();
        end
        sclk = 1'b0; step();
        chk("R3 sdo held", {11'd0, sdo}, 12'h000);
        strobe(1'b1, 1'b0); exp_a = 12'hABC;
        check_both("R3");

        // R8: strobe works with select low
        send_word(16'h0123);
        cs_n = 1'b0; step();
        strobe(1'b0, 1'b1); exp_b = 12'h123;
        cs_n = 1'b1; step();
        check_both("R8");

        // R10: strobe edge and shift edge in the same cycle
        send_word(16'h0F0F);
        cs_n = 1'b0; sclk = 1'b0; sdi = 1'b1; step();
        sclk = 1'b1; ldb_n = 1'b0; step();
        ldb_n = 1'b1; sclk = 1'b0; step();
        cs_n = 1'b1; step();
        exp_b = 12'hF0F;
        check_both("R10");

        // R9: asynchronous preset, both scales
        mid_sel = 1'b1; #2; preset_n = 1'b0; #2;
        exp_a = 12'h800; exp_b = 12'h800;
        check_both("R9 mid");
        step(); preset_n = 1'b1; step();
        check_both("R9 mid after release");
        mid_sel = 1'b0; #2; preset_n = 1'b0; #2;
        exp_a = 12'h000; exp_b = 12'h000;
        check_both("R9 zero");
        step(); preset_n = 1'b1; step();

        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

    initial begin
        #(20 * 150000);
        nfail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end
endmodule